// File: doc/BRIEF.md
# External Bus Write-After-Read Turnaround Idle Inserter

This block is the bus-state sequencer of an external bus controller. It runs external accesses one at a time and stretches a write that directly follows a read. A read occupies three bus states (T1, T2, T3) and a write occupies two (T1, T2). A slow device can keep driving the data bus after its read ends. If a write then starts at once, the controller's write data collides with that device's data. When write-after-read spacing is enabled, the block places one to four idle states (Ti) in front of such a write.

The number of idle states depends on the area the write targets. Each of the eight address areas has a select bit. That bit picks one of two shared 2-bit gap settings. A requester presents a request with an area number and a direction, and holds it until it sees the acknowledge. During idle states the bus is quiet: no chip select, no strobe, no data drive.

Top module: `bus_idle_gap`

## Requirements
- R1: While rst_ni is low, bus_st_o is 0 (free), cs_n_o is all ones, rd_n_o and wr_n_o are 1, dout_en_o and ack_o are 0.
- R2: bus_st_o encodes 0 = free, 1 = Ti, 2 = T1, 3 = T2, 4 = T3. An accepted read runs T1, T2, T3 in consecutive cycles. An accepted write runs T1, T2. The bus returns to free afterwards unless a new request is accepted in the final state.
- R3: A write accepted in the T3 state of a read (directly after it) while war_en_i is 1 gets idle states before its T1, in consecutive cycles.
- R4: The idle count is taken from gap_a_i when area_sel_i[req_area_i] is 0 and from gap_b_i when it is 1. The setting values 00, 01, 10, 11 give 1, 2, 3, 4 idle states. Area, direction and settings are sampled in the cycle of acknowledge.
- R5: With war_en_i at 0, a write accepted in a read's T3 enters T1 in the next cycle.
- R6: A read after a read, a write after a write, and a write accepted while the bus is free get no idle states.
- R7: In free and Ti states, cs_n_o is all ones, rd_n_o and wr_n_o are 1, and dout_en_o is 0.
- R8: ack_o is 1 exactly when req_i is 1 and the sequencer can accept. It can accept in the free state, in T3 of a read, or in T2 of a write. It never acknowledges during Ti, T1, or a read's T2.
- R9: During T1 to T3, cs_n_o bit [area] is 0 and all other bits are 1. rd_n_o is 0 in T2 and T3 of a read. wr_n_o is 0 in T2 of a write. dout_en_o is 1 in T1 and T2 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ack_o |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_area_i | input | 3 | Target area number 0..7 |
| war_en_i | input | 1 | Enable write-after-read idle insertion |
| area_sel_i | input | 8 | Per-area gap setting select (0 = A, 1 = B) |
| gap_a_i | input | 2 | Gap setting A (value + 1 idle states) |
| gap_b_i | input | 2 | Gap setting B (value + 1 idle states) |
| ack_o | output | 1 | Request accepted this cycle |
| bus_st_o | output | 3 | Current bus state code |
| cs_n_o | output | 8 | Active-low area chip selects |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| dout_en_o | output | 1 | Write data drive enable |

## Verification
Directed pairs run a read followed directly by a write for both select-bit values and all four setting codes. The unused setting is given a different value, so a wrong source shows up as a wrong idle count. Further directed pairs cover read-after-read, write-after-write, write after a free cycle, and a disabled feature. Each of these must show zero idle states, which separates the trigger condition from the mere presence of a write. Random request streams with random areas, directions, gaps and configuration changes check every cycle's state, acknowledge and strobes against a reference model. This exercises acknowledge timing at every state boundary.

// File: rtl/bgap_pkg.sv
package bgap_pkg;
  typedef enum logic [2:0] {
    BS_FREE = 3'd0,
    BS_IDLE = 3'd1,
    BS_T1   = 3'd2,
    BS_T2   = 3'd3,
    BS_T3   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/bgap_gap_sel.sv
module bgap_gap_sel #(
  parameter int N_AREA = 8,
  parameter int GW     = 2,
  localparam int AW    = $clog2(N_AREA)
) (
  input  logic [AW-1:0]     area_i,
  input  logic [N_AREA-1:0] sel_i,
  input  logic [GW-1:0]     gap_a_i,
  input  logic [GW-1:0]     gap_b_i,
  output logic [GW-1:0]     gap_o
);
  logic use_b;
  assign use_b = sel_i[area_i];
  assign gap_o = use_b ? gap_b_i : gap_a_i;
endmodule

// File: rtl/bgap_seq.sv
module bgap_seq
  import bgap_pkg::*;
#(
  parameter int N_AREA = 8,
  parameter int GW     = 2,
  localparam int AW    = $clog2(N_AREA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic [AW-1:0] req_area_i,
  input  logic          war_en_i,
  input  logic [GW-1:0] gap_i,
  output logic          ack_o,
  output bus_st_e       st_o,
  output logic          wr_o,
  output logic [AW-1:0] area_o
);
  bus_st_e       st_q, st_d;
  logic [GW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] area_q, area_d;
  logic          ready, after_rd, insert;

  // final state of a read is T3; of a write, T2
  assign ready    = (st_q == BS_FREE) || (st_q == BS_T3) || (st_q == BS_T2 && wr_q);
  assign after_rd = (st_q == BS_T3);
  assign ack_o    = req_i && ready;
  assign insert   = req_wr_i && after_rd && war_en_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    area_d = area_q;
    if (ack_o) begin
      st_d   = insert ? BS_IDLE : BS_T1;
      cnt_d  = gap_i;
      wr_d   = req_wr_i;
      area_d = req_area_i;
    end else begin
      unique case (st_q)
        BS_IDLE: begin
          if (cnt_q == '0) st_d = BS_T1;
          else             cnt_d = cnt_q - {{(GW-1){1'b0}}, 1'b1};
        end
        BS_T1:   st_d = BS_T2;
        BS_T2:   st_d = wr_q ? BS_FREE : BS_T3;
        BS_T3:   st_d = BS_FREE;
        default: st_d = BS_FREE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BS_FREE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      area_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      area_q <= area_d;
    end
  end

  assign st_o   = st_q;
  assign wr_o   = wr_q;
  assign area_o = area_q;
endmodule

// File: rtl/bgap_strobe.sv
module bgap_strobe
  import bgap_pkg::*;
#(
  parameter int N_AREA = 8,
  localparam int AW    = $clog2(N_AREA)
) (
  input  bus_st_e           st_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     area_i,
  output logic [N_AREA-1:0] cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dout_en_o
);
  logic active;
  assign active = (st_i == BS_T1) || (st_i == BS_T2) || (st_i == BS_T3);

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign cs_n_o[g] = !(active && (area_i == AW'(g)));
  end

  assign rd_n_o    = !(!wr_i && ((st_i == BS_T2) || (st_i == BS_T3)));
  assign wr_n_o    = !(wr_i && (st_i == BS_T2));
  assign dout_en_o = wr_i && ((st_i == BS_T1) || (st_i == BS_T2));
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bgap_pkg::*;
#(
  parameter int N_AREA = 8,
  parameter int GW     = 2,
  localparam int AW    = $clog2(N_AREA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [AW-1:0]     req_area_i,
  input  logic              war_en_i,
  input  logic [N_AREA-1:0] area_sel_i,
  input  logic [GW-1:0]     gap_a_i,
  input  logic [GW-1:0]     gap_b_i,
  output logic              ack_o,
  output logic [2:0]        bus_st_o,
  output logic [N_AREA-1:0] cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dout_en_o
);
  logic [GW-1:0] gap;
  bus_st_e       st;
  logic          cur_wr;
  logic [AW-1:0] cur_area;

  bgap_gap_sel #(.N_AREA(N_AREA), .GW(GW)) u_sel (
    .area_i  (req_area_i),
    .sel_i   (area_sel_i),
    .gap_a_i (gap_a_i),
    .gap_b_i (gap_b_i),
    .gap_o   (gap)
  );

  bgap_seq #(.N_AREA(N_AREA), .GW(GW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_wr_i   (req_wr_i),
    .req_area_i (req_area_i),
    .war_en_i   (war_en_i),
    .gap_i      (gap),
    .ack_o      (ack_o),
    .st_o       (st),
    .wr_o       (cur_wr),
    .area_o     (cur_area)
  );

  bgap_strobe #(.N_AREA(N_AREA)) u_stb (
    .st_i      (st),
    .wr_i      (cur_wr),
    .area_i    (cur_area),
    .cs_n_o    (cs_n_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .dout_en_o (dout_en_o)
  );

  assign bus_st_o = st;
endmodule

// File: rtl/bgap_chk.sv
module bgap_chk #(
  parameter int N_AREA = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              req_wr_i,
  input logic              war_en_i,
  input logic [2:0]        bus_st_o,
  input logic [N_AREA-1:0] cs_n_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              dout_en_o
);
  localparam logic [2:0] S_FREE = 3'd0, S_IDLE = 3'd1, S_T1 = 3'd2, S_T2 = 3'd3, S_T3 = 3'd4;

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_IDLE) |-> (&cs_n_o && rd_n_o && wr_n_o && !dout_en_o));

  a_r8_no_ack_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_IDLE || bus_st_o == S_T1) |-> !ack_o);

  a_r3_idle_leads_to_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_IDLE && !ack_o) |=> (bus_st_o == S_IDLE || bus_st_o == S_T1));

  a_r2_t1_then_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_T1) |=> (bus_st_o == S_T2));

  a_r9_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  a_r5_no_gap_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_T3 && ack_o && req_wr_i && !war_en_i) |=> (bus_st_o == S_T1));

  a_r6_free_no_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_FREE && ack_o) |=> (bus_st_o == S_T1));

  a_r3_war_inserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o == S_T3 && ack_o && req_wr_i && war_en_i) |=> (bus_st_o == S_IDLE));
endmodule

bind bus_idle_gap bgap_chk #(.N_AREA(N_AREA)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_o     (ack_o),
  .req_wr_i  (req_wr_i),
  .war_en_i  (war_en_i),
  .bus_st_o  (bus_st_o),
  .cs_n_o    (cs_n_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .dout_en_o (dout_en_o)
);

// File: tb/sim_bus_idle_gap.sv
`timescale 1ns/1ps
module sim_bus_idle_gap;
  localparam int NA = 8;
  localparam int AW = 3;
  localparam int GW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req = 1'b0, req_wr = 1'b0, war_en = 1'b0;
  logic [AW-1:0] req_area = '0;
  logic [NA-1:0] asel = '0;
  logic [GW-1:0] ga = '0, gb = '0;
  logic          ack, rd_n, wr_n, oe;
  logic [2:0]    st;
  logic [NA-1:0] cs_n;

  bus_idle_gap u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr), .req_area_i(req_area),
    .war_en_i(war_en), .area_sel_i(asel), .gap_a_i(ga), .gap_b_i(gb),
    .ack_o(ack), .bus_st_o(st), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .dout_en_o(oe)
  );

  int  n_run = 0, n_fail = 0, ti_seen = 0;
  bit  done = 1'b0, got_ack = 1'b0;

  // reference model, state codes per R2
  int            m_st = 0, m_left = 0;
  bit            m_wr = 1'b0;
  int            m_area = 0;

  function automatic bit m_ready();
    return (m_st == 0) || (m_st == 4) || (m_st == 3 && m_wr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_left <= 0; m_wr <= 1'b0; m_area <= 0;
    end else if (req && m_ready()) begin
      m_wr   <= req_wr;
      m_area <= int'(req_area);
      if (req_wr && m_st == 4 && war_en) begin
        m_st   <= 1;
        m_left <= 1 + int'(asel[req_area] ? gb : ga);
      end else m_st <= 2;
    end else begin
      case (m_st)
        1: if (m_left == 1) m_st <= 2; else m_left <= m_left - 1;
        2: m_st <= 3;
        3: m_st <= m_wr ? 0 : 4;
        default: m_st <= 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare outputs mid-cycle, then advance to next negedge
  task automatic step();
    int e_cs, e_rd, e_wr, e_oe;
    bit act;
    #1;
    act  = (m_st >= 2);
    e_cs = act ? int'(~(8'd1 << m_area)) : 255;
    e_rd = (act && !m_wr && m_st >= 3) ? 0 : 1;
    e_wr = (m_wr && m_st == 3) ? 0 : 1;
    e_oe = (m_wr && (m_st == 2 || m_st == 3)) ? 1 : 0;
    chk("R2/R3 bus state", int'(st), m_st);
    chk("R8 ack", int'(ack), int'(req && m_ready()));
    if (m_st <= 1) chk("R7 quiet cs/rd/wr/oe", {cs_n, rd_n, wr_n, oe}, {e_cs[7:0], 3'b110});
    else           chk("R9 strobes", {cs_n, rd_n, wr_n, oe}, {e_cs[7:0], e_rd[0], e_wr[0], e_oe[0]});
    if (st == 3'd1) ti_seen++;
    got_ack = ack;
    @(negedge clk);
  endtask

  task automatic issue(bit wr, int area);
    req = 1'b1; req_wr = wr; req_area = AW'(area);
    do step(); while (!got_ack);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    req = 1'b0;
    repeat (n) step();
  endtask

  // first access, then second either back-to-back or after the bus went free
  task automatic pair(bit w1, bit w2, bit drain, int area, int exp_ti, string tag);
    issue(w1, area);
    if (drain) idle(6);
    else if (!w1) begin req = 1'b1; req_wr = w2; req_area = AW'(area); end
    ti_seen = 0;
    issue(w2, area);
    idle(8);
    chk(tag, ti_seen, exp_ti);
  endtask

  initial begin
    #7;
    chk("R1 reset state", int'(st), 0);
    chk("R1 reset strobes", {cs_n, rd_n, wr_n, oe, ack}, {8'hFF, 4'b1100});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: both select values, all four codes, other setting differs
    war_en = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 4; v++) begin
        asel = '0; asel[5] = s[0];
        ga = s[0] ? GW'(3 - v) : GW'(v);
        gb = s[0] ? GW'(v) : GW'(3 - v);
        pair(1'b0, 1'b1, 1'b0, 5, v + 1, $sformatf("R3/R4 idle count sel=%0d code=%0d", s, v));
      end
    end
    // R4: other area with select 0 uses A
    asel = 8'h20; ga = 2'd1; gb = 2'd3;
    pair(1'b0, 1'b1, 1'b0, 2, 2, "R4 area select");
    // R5: disabled
    war_en = 1'b0;
    pair(1'b0, 1'b1, 1'b0, 5, 0, "R5 disabled no idle");
    war_en = 1'b1;
    // R6
    pair(1'b0, 1'b0, 1'b0, 5, 0, "R6 read after read");
    pair(1'b1, 1'b1, 1'b0, 5, 0, "R6 write after write");
    pair(1'b0, 1'b1, 1'b1, 5, 0, "R6 write after free");

    // random stream
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        war_en = 1'($urandom_range(0, 3) != 0);
        asel = NA'($urandom);
        ga = GW'($urandom); gb = GW'($urandom);
      end
      issue(1'($urandom), int'($urandom_range(0, NA - 1)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(8);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule